// File: doc/BRIEF.md
# Busy-Bit Free-Slot Path Finder

This unit picks an intermediate time slot for a new connection through a three-stage time-division switching network. Every word carries a busy bit: 1 while the word belongs to a call in progress, 0 when the slot is idle. The unit watches two such serial streams for one frame. The first is the output of the selected first-stage interchanger. The second is the input of the selected third-stage interchanger. It looks for a word time in which both are idle. The free test is a NOR of the streams, and the word time at which the NOR fires is the answer. No occupancy table is stored.

A third serial input, the veto stream, forces slots to read as taken. A larger network uses it to exclude slots that are busy on a far side of the path. A search is armed by a request pulse and begins at the next frame boundary. It runs over exactly `SLOTS` word times and returns the lowest free slot index, or a blocked indication when no slot qualifies. The result leaves through a valid/ready handshake. A result that has not been accepted is held unchanged, and no new search starts until it is accepted. Only the result path is subject to back-pressure: the busy-bit streams are never stalled.

Top module: `pf_path_finder`

## Requirements
- R1: After reset `res_valid` is 0 and no search is in progress.
- R2: A search starts only on a clock cycle where both `word_tick` and `frame_start` are 1 and a request was registered on an earlier cycle. A `search_req` that is 1 on the same cycle as the frame start is served at the next frame start. Without a request, no result is produced.
- R3: The search samples one word time per `word_tick`. The frame-start tick is slot 0, and each later tick is the next slot. Slot m is free when `busy_first`, `busy_third` and `veto` are all 0 at slot m's tick.
- R4: When at least one slot is free, `res_slot` is the lowest free slot index (0 to `SLOTS`-1) and `res_blocked` is 0.
- R5: When no slot of the frame is free, `res_blocked` is 1 and `res_slot` is 0.
- R6: `res_valid` rises on the clock edge that samples slot `SLOTS`-1, exactly `SLOTS` word ticks after the search start. It is 0 before that edge.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_slot` and `res_blocked` stay unchanged. The edge with both `res_valid` and `res_ready` at 1 clears `res_valid`.
- R8: A request arriving during a search is held and served at the first frame start after that search ends and its result has been accepted.
- R9: Cycles with `word_tick` at 0 are ignored: the busy, veto and frame-start values on them have no effect, and the slot position does not advance.
- R10: A frame start does not begin a search while `res_valid` is 1. The pending request is kept for a later frame start.
- R11: A 1 on `veto` makes its slot unusable even when both busy streams are 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_tick | input | 1 | Marks a cycle that carries one word time |
| frame_start | input | 1 | With `word_tick`, marks slot 0 of a frame |
| busy_first | input | 1 | Busy bit of the first-stage interchanger output |
| busy_third | input | 1 | Busy bit of the third-stage interchanger input |
| veto | input | 1 | 1 forces the current slot to read as unavailable |
| search_req | input | 1 | Pulse that requests a search |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Consumer accepts the result |
| res_slot | output | $clog2(SLOTS) | Chosen intermediate slot; 0 when blocked |
| res_blocked | output | 1 | No free slot existed in the searched frame |

## Verification
The hardest situation to reach is a request that becomes pending while an earlier result is still unaccepted and a frame boundary passes. Reaching it needs a finished search, a held result, a second request, and a full frame driven past the ports. The bench does this by leaving `res_ready` low across an entire frame whose busy pattern would give a different answer. It then accepts the result and runs one more frame. The unchanged held result and the later, second answer show that the request was kept rather than lost or served early. A similar directed case uses idle cycles between word ticks that carry deliberately free-looking values, so that any sampling on idle cycles would move the reported slot.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_MIN_SLOTS = 2;

  function automatic logic slot_free(input logic b1, input logic b3, input logic vt);
    return ~(b1 | b3 | vt);
  endfunction
endpackage

// File: rtl/pf_req_latch.sv
module pf_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic consume,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= req | (pending & ~consume);
  end
endmodule

// File: rtl/pf_slot_scan.sv
module pf_slot_scan #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_tick,
  input  logic          start,
  input  logic          busy_first,
  input  logic          busy_third,
  input  logic          veto,
  output logic          active,
  output logic          done,
  output logic          done_found,
  output logic [SW-1:0] done_slot,
  output logic [SW-1:0] cnt
);
  import pf_pkg::*;

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic          found;
  logic [SW-1:0] best;
  logic          sample;
  logic [SW-1:0] idx;
  logic          found_eff;
  logic          free_now;

  assign sample    = word_tick & (active | start);
  assign idx       = start ? '0 : cnt;
  assign found_eff = found & ~start;
  assign free_now  = slot_free(busy_first, busy_third, veto);

  assign done       = sample & (idx == LAST);
  assign done_found = found_eff | free_now;
  assign done_slot  = found_eff ? best : (free_now ? idx : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      found  <= 1'b0;
      best   <= '0;
    end else if (sample) begin
      if (idx == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
        found  <= 1'b0;
      end else begin
        active <= 1'b1;
        cnt    <= idx + 1'b1;
        if (free_now && !found_eff) begin
          found <= 1'b1;
          best  <= idx;
        end else begin
          found <= found_eff;
        end
      end
    end
  end
endmodule

// File: rtl/pf_result_hold.sv
module pf_result_hold #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_found,
  input  logic [SW-1:0] load_slot,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [SW-1:0] res_slot,
  output logic          res_blocked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_slot    <= '0;
      res_blocked <= 1'b0;
    end else if (load) begin
      res_valid   <= 1'b1;
      res_slot    <= load_found ? load_slot : '0;
      res_blocked <= ~load_found;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_path_finder.sv
module pf_path_finder #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_tick,
  input  logic          frame_start,
  input  logic          busy_first,
  input  logic          busy_third,
  input  logic          veto,
  input  logic          search_req,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [SW-1:0] res_slot,
  output logic          res_blocked
);
  import pf_pkg::*;

  logic          pending;
  logic          start;
  logic          scan_active;
  logic          scan_done;
  logic          scan_found;
  logic [SW-1:0] scan_slot;
  logic [SW-1:0] scan_cnt;

  initial begin
    if (SLOTS < PF_MIN_SLOTS) $error("SLOTS must be at least %0d", PF_MIN_SLOTS);
  end

  assign start = word_tick & frame_start & pending & ~res_valid & ~scan_active;

  pf_req_latch u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (search_req),
    .consume (start),
    .pending (pending)
  );

  pf_slot_scan #(.SLOTS(SLOTS)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_tick  (word_tick),
    .start      (start),
    .busy_first (busy_first),
    .busy_third (busy_third),
    .veto       (veto),
    .active     (scan_active),
    .done       (scan_done),
    .done_found (scan_found),
    .done_slot  (scan_slot),
    .cnt        (scan_cnt)
  );

  pf_result_hold #(.SW(SW)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (scan_done),
    .load_found  (scan_found),
    .load_slot   (scan_slot),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_slot    (res_slot),
    .res_blocked (res_blocked)
  );
endmodule

// File: rtl/pf_path_finder_chk.sv
module pf_path_finder_chk #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_tick,
  input logic          frame_start,
  input logic          scan_active,
  input logic          scan_done,
  input logic [SW-1:0] scan_cnt,
  input logic          res_valid,
  input logic          res_ready,
  input logic [SW-1:0] res_slot,
  input logic          res_blocked
);
  AST_START_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_active) |-> $past(frame_start && word_tick)); // R2

  AST_IDLE_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && !word_tick) |=> (scan_active && $stable(scan_cnt))); // R9

  AST_DONE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> res_valid); // R6

  AST_NO_START_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !res_valid); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_slot) && $stable(res_blocked))); // R7

  AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_blocked) |-> (res_slot == '0)); // R5

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (32'(res_slot) < SLOTS)); // R4
endmodule

bind pf_path_finder pf_path_finder_chk #(.SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_tick   (word_tick),
  .frame_start (frame_start),
  .scan_active (scan_active),
  .scan_done   (scan_done),
  .scan_cnt    (scan_cnt),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_slot    (res_slot),
  .res_blocked (res_blocked)
);

// File: tb/sim_pf_path_finder.sv
`timescale 1ns/1ps
module sim_pf_path_finder;
  localparam int M = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_tick = 1'b0, frame_start = 1'b0;
  logic busy_first = 1'b0, busy_third = 1'b0, veto = 1'b0;
  logic search_req = 1'b0, res_ready = 1'b0;
  logic res_valid, res_blocked;
  logic [2:0] res_slot;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pf_path_finder #(.SLOTS(M)) u0 (
    .clk(clk), .rst_n(rst_n), .word_tick(word_tick), .frame_start(frame_start),
    .busy_first(busy_first), .busy_third(busy_third), .veto(veto),
    .search_req(search_req), .res_valid(res_valid), .res_ready(res_ready),
    .res_slot(res_slot), .res_blocked(res_blocked)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic wt, input logic fs, input logic a,
                       input logic b, input logic v, input logic rq);
    @(negedge clk);
    word_tick = wt; frame_start = fs; busy_first = a;
    busy_third = b; veto = v; search_req = rq;
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    word_tick = 0; frame_start = 0; busy_first = 0;
    busy_third = 0; veto = 0; search_req = 0;
  endtask

  task automatic request();
    drive(0, 0, 0, 0, 0, 1);
  endtask

  // One frame of word ticks; req_at >= 0 raises search_req on that tick.
  // When gap is set, an idle cycle with free-looking values precedes each tick.
  task automatic run_frame(input logic [M-1:0] a, input logic [M-1:0] b,
                           input logic [M-1:0] v, input int req_at, input bit gap,
                           input bit expect_search);
    for (int i = 0; i < M; i++) begin
      if (gap) drive(0, (i == 0), 0, 0, 0, 0);
      if (i == M - 1 && expect_search) check("R6 valid before last slot", res_valid, 0);
      drive(1, (i == 0), a[i], b[i], v[i], (i == req_at));
    end
    settle();
  endtask

  task automatic accept();
    @(negedge clk); res_ready = 1;
    @(posedge clk);
    @(negedge clk); res_ready = 0;
    check("R7 valid cleared after handshake", res_valid, 0);
  endtask

  function automatic int lowest_free(input logic [M-1:0] a, input logic [M-1:0] b,
                                     input logic [M-1:0] v);
    for (int i = 0; i < M; i++)
      if (!a[i] && !b[i] && !v[i]) return i;
    return -1;
  endfunction

  task automatic expect_result(input string req, input logic [M-1:0] a,
                               input logic [M-1:0] b, input logic [M-1:0] v);
    int e;
    e = lowest_free(a, b, v);
    check({req, " valid"}, res_valid, 1);
    check({req, " blocked"}, res_blocked, (e < 0));
    check({req, " slot"}, res_slot, (e < 0) ? 0 : e);
  endtask

  task automatic t_reset();
    check("R1 reset valid", res_valid, 0);
    repeat (3) drive(1, 1, 0, 0, 0, 0);
    settle();
    check("R1 no search without request", res_valid, 0);
  endtask

  task automatic t_basic();
    request();
    run_frame(8'b0001_0111, 8'b0000_1100, 8'h00, -1, 0, 1);
    expect_result("R3 R4 R6 basic", 8'b0001_0111, 8'b0000_1100, 8'h00);
    accept();
    request();
    run_frame(8'hF0, 8'h00, 8'h00, -1, 0, 1);
    expect_result("R4 slot zero free", 8'hF0, 8'h00, 8'h00);
    accept();
    request();
    run_frame(8'h3F, 8'h40, 8'h00, -1, 0, 1);
    expect_result("R4 last slot only", 8'h3F, 8'h40, 8'h00);
    accept();
  endtask

  task automatic t_veto();
    request();
    run_frame(8'h00, 8'h00, 8'b0000_0111, -1, 0, 1);
    expect_result("R11 veto", 8'h00, 8'h00, 8'b0000_0111);
    accept();
  endtask

  task automatic t_blocked();
    request();
    run_frame(8'h0F, 8'hB0, 8'h40, -1, 0, 1);
    expect_result("R5 blocked", 8'h0F, 8'hB0, 8'h40);
    accept();
  endtask

  task automatic t_no_request();
    run_frame(8'h00, 8'h00, 8'h00, -1, 0, 0);
    check("R2 no request no result", res_valid, 0);
  endtask

  task automatic t_same_cycle_req();
    run_frame(8'h01, 8'h00, 8'h00, 0, 0, 0);
    check("R2 same-cycle request deferred", res_valid, 0);
    run_frame(8'h03, 8'h00, 8'h00, -1, 0, 1);
    expect_result("R2 deferred request served", 8'h03, 8'h00, 8'h00);
    accept();
  endtask

  task automatic t_held_req();
    request();
    run_frame(8'h01, 8'h00, 8'h00, 3, 0, 1);
    expect_result("R8 first search", 8'h01, 8'h00, 8'h00);
    accept();
    run_frame(8'h0F, 8'h10, 8'h00, -1, 0, 1);
    expect_result("R8 held request served", 8'h0F, 8'h10, 8'h00);
    accept();
  endtask

  task automatic t_gaps();
    request();
    run_frame(8'h07, 8'h00, 8'h00, -1, 1, 1);
    expect_result("R9 idle cycles ignored", 8'h07, 8'h00, 8'h00);
    accept();
  endtask

  task automatic t_backpressure();
    request();
    run_frame(8'h1F, 8'h00, 8'h00, -1, 0, 1);
    expect_result("R7 first result", 8'h1F, 8'h00, 8'h00);
    request();
    run_frame(8'h00, 8'h00, 8'h00, -1, 0, 0);
    expect_result("R7 R10 result held through frame", 8'h1F, 8'h00, 8'h00);
    accept();
    run_frame(8'h03, 8'h04, 8'h00, -1, 0, 1);
    expect_result("R10 pending request served after accept", 8'h03, 8'h04, 8'h00);
    accept();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_basic();
    t_veto();
    t_blocked();
    t_no_request();
    t_same_cycle_req();
    t_held_req();
    t_gaps();
    t_backpressure();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule